// File: doc/BRIEF.md
# Two-Stage Pointer-Capable Memory Unit

This block forms the memory part of a six-stage in-order pipeline in which the memory stage is split into two back-to-back stages, MEM1 and MEM2. Both stages share one synchronous, single-port data memory. Each cycle the EX stage hands in an opcode, an effective address, store data and a destination register index. The block answers with a write-back triple toward WB, made of a valid strobe, a destination and a data word.

Four memory operations are supported. An ordinary load reads one word, and an ordinary store writes one word; each makes its single access in MEM1. A pointer load first reads a pointer word at the effective address and then reads the word the pointer names. A pointer store also reads the pointer first and then writes the store data to the pointer address. For both pointer operations, the pointer read happens in MEM1 and the second access in MEM2. The memory read register carries the pointer across the MEM1/MEM2 boundary.

Hazard handling stays upstream. The caller must leave a bubble behind any pointer operation before the next memory operation, because otherwise MEM1 and MEM2 would need the port in the same cycle. A built-in check flags any such cycle.

Top module: `ptr_mem_unit`

## Requirements
- R1: Ordinary load (opcode 1) writes back mem[addr] to its destination: wb_valid is high with that data three clock edges after the opcode is presented.
- R2: Ordinary store (opcode 2) writes the store data to mem[addr] in the cycle after issue, makes no access in MEM2 and produces no write-back.
- R3: Pointer load (opcode 3) writes back mem[P] to its destination, with the same latency as R1. P is the low AW bits of mem[addr].
- R4: Pointer store (opcode 4) writes the store data to mem[P], with P as in R3, and produces no write-back.
- R5: Each of opcodes 1 to 4 requests the port in the cycle after issue. Opcodes 3 and 4 request it again in the following cycle. In a pointer op's first cycle and in a load's only cycle, the request is a read.
- R6: Opcode 0 and the unused codes 5, 6 and 7 are bubbles. They make no memory request and produce no write-back, whatever the other EX inputs hold.
- R7: A MEM1 access uses the EX address and store data. A MEM2 access uses the pointer read in MEM1 and the pointer op's store data. MEM1 and MEM2 never both request the port in one cycle.
- R8: A synchronous, active-high reset clears all in-flight operations. While reset holds and in the cycle after it, wb_valid and mem_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_op | input | 3 | Opcode from EX (0 bubble, 1 load, 2 store, 3 pointer load, 4 pointer store) |
| ex_addr | input | AW | Effective address from EX |
| ex_wdata | input | DW | Store data (regB value) from EX |
| ex_dest | input | RW | Destination register index (regB field) |
| mem_en | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Registered read data, valid the cycle after a read |
| wb_valid | output | 1 | Register write-back strobe |
| wb_dest | output | RW | Write-back register index |
| wb_data | output | DW | Write-back data |

## Verification
Two port uses can fall in the same cycle. One is the second access of a pointer operation in MEM2. The other is the single access, or the pointer read, of the instruction right behind it in MEM1. The bench models the upstream stall by inserting exactly one bubble after every pointer operation. It then checks the port address, enable, write enable and write data every cycle against a program-order model, so a wrong stage priority or a wrong pointer source shows up directly. Directed sequences put a load's MEM1 read in the same cycle as a pointer load's write-back from the read register, and put a store's MEM1 write one cycle before a pointer read of the same word. Random mixes then confirm that results still arrive in order.

// File: rtl/ptrmem_pkg.sv
package ptrmem_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_LD  = 3'd1,
    OP_ST  = 3'd2,
    OP_PLD = 3'd3,
    OP_PST = 3'd4
  } mop_e;

  // Unused codes collapse to a bubble.
  function automatic mop_e op_decode(input logic [2:0] code);
    case (code)
      3'd1:    return OP_LD;
      3'd2:    return OP_ST;
      3'd3:    return OP_PLD;
      3'd4:    return OP_PST;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic uses_port(input mop_e op);
    return op != OP_NOP;
  endfunction

  function automatic logic is_indirect(input mop_e op);
    return (op == OP_PLD) || (op == OP_PST);
  endfunction

  function automatic logic writes_reg(input mop_e op);
    return (op == OP_LD) || (op == OP_PLD);
  endfunction

endpackage

// File: rtl/ptrmem_m1.sv
module ptrmem_m1
  import ptrmem_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    ex_op,
  input  logic [AW-1:0] ex_addr,
  input  logic [DW-1:0] ex_wdata,
  input  logic [RW-1:0] ex_dest,
  output mop_e          m1_op,
  output logic [AW-1:0] m1_addr,
  output logic [DW-1:0] m1_wdata,
  output logic [RW-1:0] m1_dest,
  output logic          m1_req,
  output logic          m1_we
);

  always_ff @(posedge clk) begin
    if (rst) m1_op <= OP_NOP;
    else     m1_op <= op_decode(ex_op);
    m1_addr  <= ex_addr;
    m1_wdata <= ex_wdata;
    m1_dest  <= ex_dest;
  end

  // Every real op touches memory here; only a plain store writes.
  assign m1_req = uses_port(m1_op);
  assign m1_we  = (m1_op == OP_ST);

endmodule

// File: rtl/ptrmem_m2.sv
module ptrmem_m2
  import ptrmem_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  mop_e          m1_op,
  input  logic [DW-1:0] m1_wdata,
  input  logic [RW-1:0] m1_dest,
  input  logic [AW-1:0] ptr_word,
  output mop_e          m2_op,
  output logic [RW-1:0] m2_dest,
  output logic          m2_req,
  output logic          m2_we,
  output logic [AW-1:0] m2_addr,
  output logic [DW-1:0] m2_wdata
);

  always_ff @(posedge clk) begin
    if (rst) m2_op <= OP_NOP;
    else     m2_op <= m1_op;
    m2_wdata <= m1_wdata;
    m2_dest  <= m1_dest;
  end

  // The read register of the memory holds the pointer fetched in MEM1.
  assign m2_req  = is_indirect(m2_op);
  assign m2_we   = (m2_op == OP_PST);
  assign m2_addr = ptr_word;

  // R4: a MEM2 write can only follow a pointer store that was in MEM1.
  assert_pst_origin_R4: assert property (@(posedge clk) disable iff (rst)
    m2_we |-> $past(m1_op == OP_PST));

endmodule

// File: rtl/ptrmem_wb.sv
module ptrmem_wb
  import ptrmem_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  mop_e          m2_op,
  input  logic [RW-1:0] m2_dest,
  input  logic [DW-1:0] rdata,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dest,
  output logic [DW-1:0] wb_data,
  output logic          wb_from_ptr
);

  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      wb_from_ptr <= 1'b0;
    end else begin
      wb_valid    <= writes_reg(m2_op);
      wb_from_ptr <= (m2_op == OP_PLD);
    end
    wb_dest <= m2_dest;
    held    <= rdata;   // ordinary load data sits on rdata during MEM2
  end

  // Pointer-load data arrives in the read register one cycle later.
  assign wb_data = wb_from_ptr ? rdata : held;

endmodule

// File: rtl/ptr_mem_unit.sv
module ptr_mem_unit
  import ptrmem_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    ex_op,
  input  logic [AW-1:0] ex_addr,
  input  logic [DW-1:0] ex_wdata,
  input  logic [RW-1:0] ex_dest,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dest,
  output logic [DW-1:0] wb_data
);

  localparam int PTRW = (AW < DW) ? AW : DW;

  mop_e          m1_op, m2_op;
  logic [AW-1:0] m1_addr, m2_addr;
  logic [DW-1:0] m1_wdata, m2_wdata;
  logic [RW-1:0] m1_dest, m2_dest;
  logic          m1_req, m1_we, m2_req, m2_we, wb_from_ptr;
  logic [AW-1:0] ptr_word;

  assign ptr_word = AW'(mem_rdata[PTRW-1:0]);

  ptrmem_m1 #(.AW(AW), .DW(DW), .RW(RW)) u_m1 (
    .clk(clk), .rst(rst), .ex_op(ex_op), .ex_addr(ex_addr),
    .ex_wdata(ex_wdata), .ex_dest(ex_dest), .m1_op(m1_op),
    .m1_addr(m1_addr), .m1_wdata(m1_wdata), .m1_dest(m1_dest),
    .m1_req(m1_req), .m1_we(m1_we));

  ptrmem_m2 #(.AW(AW), .DW(DW), .RW(RW)) u_m2 (
    .clk(clk), .rst(rst), .m1_op(m1_op), .m1_wdata(m1_wdata),
    .m1_dest(m1_dest), .ptr_word(ptr_word), .m2_op(m2_op),
    .m2_dest(m2_dest), .m2_req(m2_req), .m2_we(m2_we),
    .m2_addr(m2_addr), .m2_wdata(m2_wdata));

  ptrmem_wb #(.DW(DW), .RW(RW)) u_wb (
    .clk(clk), .rst(rst), .m2_op(m2_op), .m2_dest(m2_dest),
    .rdata(mem_rdata), .wb_valid(wb_valid), .wb_dest(wb_dest),
    .wb_data(wb_data), .wb_from_ptr(wb_from_ptr));

  // Single port: the older instruction in MEM2 wins if both ask.
  always_comb begin
    mem_en = m1_req | m2_req;
    if (m2_req) begin
      mem_we    = m2_we;
      mem_addr  = m2_addr;
      mem_wdata = m2_wdata;
    end else begin
      mem_we    = m1_we;
      mem_addr  = m1_addr;
      mem_wdata = m1_wdata;
    end
  end

  // R7: upstream stalling must keep the two stages off the port together.
  assert_one_port_user_R7: assert property (@(posedge clk) disable iff (rst)
    !(m1_req && m2_req));

  // R6: with a bubble in MEM1 and no pointer op in MEM2 the port is idle.
  assert_bubble_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (m1_op == OP_NOP && m2_op != OP_PLD && m2_op != OP_PST) |-> !mem_en);

  // R3: a pointer-load write-back follows a read issued in the prior cycle.
  assert_ptr_second_read_R3: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_from_ptr) |-> ($past(mem_en) && !$past(mem_we)));

  // R2: a plain store has nothing left to do in MEM2.
  assert_store_single_R2: assert property (@(posedge clk) disable iff (rst)
    m1_we |=> !m2_req);

  // R8: reset leaves the unit idle on the next cycle.
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (!wb_valid && !mem_en));

endmodule

// File: tb/test_ptr_mem_unit.sv
`timescale 1ns/1ps
module test_ptr_mem_unit;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int RW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int DMASK = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ram_init = 1'b1;
  logic [2:0]    ex_op = 3'd0;
  logic [AW-1:0] ex_addr = '0;
  logic [DW-1:0] ex_wdata = '0;
  logic [RW-1:0] ex_dest = '0;
  logic          mem_en, mem_we, wb_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, wb_data;
  logic [DW-1:0] mem_rdata = '0;
  logic [RW-1:0] wb_dest;

  logic [DW-1:0] ram   [0:DEPTH-1];
  logic [DW-1:0] model [0:DEPTH-1];

  int checks = 0;
  int fails  = 0;
  int last_op = 0;
  int h_op [1:3];
  int h_addr [1:3];
  int h_ptr [1:3];
  int h_wd [1:3];
  int h_dest [1:3];
  int h_data [1:3];

  always #4 clk = ~clk;

  ptr_mem_unit #(.AW(AW), .DW(DW), .RW(RW)) i_ptr_mem_unit (
    .clk(clk), .rst(rst), .ex_op(ex_op), .ex_addr(ex_addr),
    .ex_wdata(ex_wdata), .ex_dest(ex_dest), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_dest(wb_dest),
    .wb_data(wb_data));

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 1237 + 91);
  endfunction

  // Synchronous single-port memory with a read register.
  always @(posedge clk) begin
    if (ram_init) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= init_word(i);
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  function automatic string tag_of(input int op);
    case (op)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic bit is_ptr(input int op);
    return op == 3 || op == 4;
  endfunction

  function automatic bit is_mem(input int op);
    return op >= 1 && op <= 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Compare outputs at a negedge: slot 1 is in MEM1, 2 in MEM2, 3 in WB.
  task automatic check_cycle;
    bit exp_en, exp_we, exp_v;
    int exp_addr, exp_wd;
    exp_en = is_mem(h_op[1]) || is_ptr(h_op[2]);
    exp_we = (h_op[1] == 2) || (h_op[2] == 4);
    chk(mem_en == exp_en, "R5/R6 port enable", int'(mem_en), int'(exp_en));
    if (exp_en) begin
      chk(mem_we == exp_we, "R5 write enable", int'(mem_we), int'(exp_we));
      exp_addr = is_ptr(h_op[2]) ? h_ptr[2] : h_addr[1];
      chk(int'(mem_addr) == exp_addr, "R7 port address", int'(mem_addr), exp_addr);
      if (exp_we) begin
        exp_wd = (h_op[2] == 4) ? h_wd[2] : h_wd[1];
        chk(int'(mem_wdata) == exp_wd, "R7 port write data", int'(mem_wdata), exp_wd);
      end
    end
    exp_v = (h_op[3] == 1) || (h_op[3] == 3);
    chk(wb_valid == exp_v, tag_of(h_op[3]), int'(wb_valid), int'(exp_v));
    if (exp_v) begin
      chk(int'(wb_dest) == h_dest[3], tag_of(h_op[3]), int'(wb_dest), h_dest[3]);
      chk(int'(wb_data) == h_data[3], tag_of(h_op[3]), int'(wb_data), h_data[3]);
    end
  endtask

  task automatic issue(input int op, input int addr, input int wd, input int dst);
    int ptr, ed;
    @(negedge clk);
    check_cycle();
    ptr = int'(model[addr][AW-1:0]);
    ed = 0;
    case (op)
      1: ed = int'(model[addr]);
      2: model[addr] = DW'(wd);
      3: ed = int'(model[ptr]);
      4: model[ptr] = DW'(wd);
      default: ;
    endcase
    for (int k = 3; k > 1; k--) begin
      h_op[k] = h_op[k-1];  h_addr[k] = h_addr[k-1]; h_ptr[k] = h_ptr[k-1];
      h_wd[k] = h_wd[k-1];  h_dest[k] = h_dest[k-1]; h_data[k] = h_data[k-1];
    end
    h_op[1] = op; h_addr[1] = addr; h_ptr[1] = ptr;
    h_wd[1] = wd & DMASK; h_dest[1] = dst; h_data[1] = ed;
    ex_op = 3'(op); ex_addr = AW'(addr); ex_wdata = DW'(wd); ex_dest = RW'(dst);
    last_op = op;
  endtask

  task automatic clear_hist;
    for (int k = 1; k <= 3; k++) begin
      h_op[k] = 0; h_addr[k] = 0; h_ptr[k] = 0;
      h_wd[k] = 0; h_dest[k] = 0; h_data[k] = 0;
    end
    last_op = 0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    check_cycle();
    rst = 1'b1;
    ex_op = 3'd0;
    @(negedge clk);
    @(negedge clk);
    chk(!wb_valid, "R8 wb_valid in reset", int'(wb_valid), 0);
    chk(!mem_en, "R8 mem_en in reset", int'(mem_en), 0);
    rst = 1'b0;
    clear_hist();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    int op;
    void'($urandom(32'd2024));
    clear_hist();
    for (int i = 0; i < DEPTH; i++) model[i] = init_word(i);
    repeat (3) @(negedge clk);
    ram_init = 1'b0;
    chk(!wb_valid, "R8 reset wb_valid", int'(wb_valid), 0);
    chk(!mem_en, "R8 reset mem_en", int'(mem_en), 0);
    rst = 1'b0;

    // R1/R2: store then load of the same word, back to back.
    issue(2, 5, 16'h1234, 0);
    issue(1, 5, 0, 3);
    // R4 then R3 through the same pointer, one bubble after each (R7).
    issue(4, 9, 16'hBEEF, 0);
    issue(0, 0, 0, 0);
    issue(3, 9, 0, 6);
    issue(0, 0, 0, 0);
    // R1 read in MEM1 while the pointer-load result leaves the read register.
    issue(1, 9, 0, 2);
    // R6: bubbles with busy-looking fields.
    issue(5, 33, 16'hFFFF, 7);
    issue(7, 12, 16'hAAAA, 1);
    issue(6, 63, 16'h5555, 4);
    // Store to a word, then immediately use that word as a pointer.
    issue(2, 20, 3, 0);
    issue(3, 20, 0, 5);
    issue(0, 0, 0, 0);
    issue(1, 1, 0, 1);
    issue(1, 2, 0, 2);
    issue(1, 3, 0, 3);

    // Random mix; one bubble follows each pointer op (R7 contract).
    for (int n = 0; n < 4000; n++) begin
      op = $urandom_range(0, 7);
      if (is_ptr(last_op) && is_mem(op)) issue(0, 0, 0, 0);
      issue(op, $urandom_range(0, DEPTH - 1), $urandom_range(0, DMASK),
            $urandom_range(0, (1 << RW) - 1));
    end

    // R8: reset with loads in flight.
    if (is_ptr(last_op)) issue(0, 0, 0, 0);
    issue(3, 7, 0, 1);
    issue(0, 0, 0, 0);
    issue(1, 8, 0, 2);
    do_reset();
    issue(1, 8, 0, 4);
    repeat (4) issue(0, 0, 0, 0);

    // R2/R4: the memory image must match the program-order model.
    begin
      int bad, first_bad;
      bad = 0;
      first_bad = -1;
      for (int i = 0; i < DEPTH; i++)
        if (ram[i] !== model[i]) begin
          bad++;
          if (first_bad < 0) first_bad = i;
        end
      chk(bad == 0, "R2/R4 memory image mismatches", bad, 0);
    end
    report();
    $finish;
  end

endmodule